// File: doc/BRIEF.md
# Shadow Region Channel Access Filter

This block holds the per-channel enable, interrupt-pending and QDMA-enable state of a DMA controller and places nine address windows over it. One window is global and unfiltered. The other eight are alias windows, called shadow regions, and each one sees the same state through its own ownership masks. Each region owns a 64-bit mask and a 4-bit mask. The 64-bit mask covers the 64 DMA channels and also the 64 six-bit completion codes. The 4-bit mask covers the QDMA channels. Software gives a task a region and sets only that task's bits in the region's masks. The task can then touch only the channels and completion codes it owns, with no arbitration in the data path.

An address is a 4-bit view selector followed by a 6-bit word offset. Views 0 to 7 select the shadow regions, view 8 selects the global window, and views 9 to 15 decode to nothing. Every word offset below 32 has the same meaning in every view. Offsets from 32 upward hold the mask registers, and these exist only in the global view. Completion events arrive on a separate strobe with a 6-bit code. The block drives one interrupt line per region. A line is high while any pending code that the region owns is set.

Top module: `shadow_access_filter`

## Requirements
- R1: After reset every enable, pending and mask bit is zero, `bus_rdata` is zero and no `region_irq` line is high.
- R2: In the global view (selector 8), offset 0 reads and writes channel enables 0–31 directly, and offset 1 does the same for channels 32–63. Region k's masks are read and written at offset 32+4k (DMA mask bits 31:0), 32+4k+1 (DMA mask bits 63:32) and 32+4k+2 (QDMA mask in data bits 3:0).
- R3: A write through shadow view k (selector k, 0–7) to an enable word (offset 0 or 1) changes only the bits whose DMA mask bit is 1 in region k. Unowned bits keep their value.
- R4: A read through shadow view k returns 0 in every bit that region k does not own and the live value in every bit it owns. This holds for the enable words and for the pending words (offset 6 for codes 0–31, offset 7 for codes 32–63).
- R5: Offsets 2/3 set enables and offsets 4/5 clear them (write 1 to act, low/high word). The view's mask is applied to the data first, so zero bits and unowned bits leave state unchanged. These offsets read as zero.
- R6: A strobe on `done_valid` with code n sets pending bit n on the next clock edge. `region_irq[k]` is high while some pending bit is owned by region k. Offsets 8/9 clear pending bits on a write of 1, filtered by the view's DMA mask.
- R7: The QDMA enables are read and written at offset 10 (data bits 3:0), set at offset 11 and cleared at offset 12. A shadow write has no effect on a QDMA channel whose bit is clear in that region's QDMA mask, and a shadow read returns 0 for that channel.
- R8: Offsets from 32 upward are ignored for writes through a shadow view and read back as zero there. Masks change only through the global view.
- R9: An access to selector 9–15, to offsets 13–31, or to field 3 of a mask group reads zero and changes no state.
- R10: Several regions may own the same channel. Each of them can set, clear and read it, and no exclusivity is enforced.
- R11: Read data appears on `bus_rdata` in the cycle after the read is accepted. In any cycle after a cycle with no read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | {view selector[3:0], word offset[5:0]} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| done_valid | input | 1 | Completion event strobe |
| done_code | input | 6 | Completion code of the event |
| chan_en | output | 64 | Live DMA channel enables |
| qchan_en | output | 4 | Live QDMA channel enables |
| region_irq | output | 8 | Per-region interrupt |

## Verification
The assertions check on every cycle that a shadow write never changes an unowned enable or QDMA bit, and that a shadow write never changes a mask. They also check that a write to an undecoded view leaves state unchanged, that idle or undecoded cycles return zero read data, and that a completion event always sets its pending bit. The bench scenarios show the behaviour that depends on particular data: which bits a read masks out, the direction of each set and clear alias, the per-region interrupt pattern when ownership overlaps, and the exact layout of the mask registers.

// File: rtl/shadow_access_filter.sv
module shadow_access_filter #(
  parameter int NR        = 8,
  parameter int DW        = 32,
  parameter int QN        = 4,
  parameter int VW        = 4,
  parameter int OFFW      = 6,
  parameter int MASK_BASE = 32,
  parameter int CW        = $clog2(2*DW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [VW+OFFW-1:0]   bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 done_valid,
  input  logic [CW-1:0]        done_code,
  output logic [2*DW-1:0]      chan_en,
  output logic [QN-1:0]        qchan_en,
  output logic [NR-1:0]        region_irq
);
  localparam int NCH = 2*DW;
  localparam int RW  = $clog2(NR);
  localparam logic [OFFW-1:0] O_EN_LO = 'd0,  O_EN_HI = 'd1;
  localparam logic [OFFW-1:0] O_ES_LO = 'd2,  O_ES_HI = 'd3;
  localparam logic [OFFW-1:0] O_EC_LO = 'd4,  O_EC_HI = 'd5;
  localparam logic [OFFW-1:0] O_IP_LO = 'd6,  O_IP_HI = 'd7;
  localparam logic [OFFW-1:0] O_IC_LO = 'd8,  O_IC_HI = 'd9;
  localparam logic [OFFW-1:0] O_QEN   = 'd10, O_QS    = 'd11, O_QC = 'd12;
  localparam logic [OFFW-1:0] O_MBASE = OFFW'(MASK_BASE);

  logic [NR-1:0][NCH-1:0] dmask_q;
  logic [NR-1:0][QN-1:0]  qmask_q;
  logic [NCH-1:0]         en_q, pend_q, pend_nxt;
  logic [QN-1:0]          qen_q;

  wire [VW-1:0]   view   = bus_addr[VW+OFFW-1:OFFW];
  wire [OFFW-1:0] off    = bus_addr[OFFW-1:0];
  wire [RW-1:0]   rsel   = view[RW-1:0];
  wire            is_glb = (int'(view) == NR);
  wire            is_shd = (int'(view) < NR);
  wire            hw     = off[0];
  wire            wr     = bus_valid & bus_we & (is_glb | is_shd);
  wire            rd     = bus_valid & ~bus_we & (is_glb | is_shd);

  wire [NCH-1:0]  dm   = is_glb ? {NCH{1'b1}} : (is_shd ? dmask_q[rsel] : '0);
  wire [QN-1:0]   qm   = is_glb ? {QN{1'b1}}  : (is_shd ? qmask_q[rsel] : '0);
  wire [DW-1:0]   m_w  = hw ? dm[NCH-1:DW] : dm[DW-1:0];
  wire [DW-1:0]   wdm  = bus_wdata & m_w;
  wire [QN-1:0]   qwd  = bus_wdata[QN-1:0] & qm;

  wire [OFFW-1:0] mofs    = off - O_MBASE;
  wire [RW-1:0]   mreg    = mofs[2 +: RW];
  wire [1:0]      mfld    = mofs[1:0];
  wire            in_mask = is_glb && (off >= O_MBASE) && (int'(mofs[OFFW-1:2]) < NR);

  always_comb begin
    pend_nxt = pend_q;
    if (wr && (off == O_IC_LO || off == O_IC_HI))
      pend_nxt[hw*DW +: DW] = pend_q[hw*DW +: DW] & ~wdm;
    if (done_valid)
      pend_nxt[done_code] = 1'b1;
  end

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (off)
      O_EN_LO, O_EN_HI: rd_val = en_q[hw*DW +: DW] & m_w;
      O_IP_LO, O_IP_HI: rd_val = pend_q[hw*DW +: DW] & m_w;
      O_QEN:            rd_val[QN-1:0] = qen_q & qm;
      default:
        if (in_mask) begin
          case (mfld)
            2'd0:    rd_val = dmask_q[mreg][DW-1:0];
            2'd1:    rd_val = dmask_q[mreg][NCH-1:DW];
            2'd2:    rd_val[QN-1:0] = qmask_q[mreg];
            default: rd_val = '0;
          endcase
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q   <= '0;
      qmask_q   <= '0;
      en_q      <= '0;
      pend_q    <= '0;
      qen_q     <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q    <= pend_nxt;
      bus_rdata <= rd ? rd_val : '0;
      if (wr) begin
        case (off)
          O_EN_LO, O_EN_HI: en_q[hw*DW +: DW] <= (en_q[hw*DW +: DW] & ~m_w) | wdm;
          O_ES_LO, O_ES_HI: en_q[hw*DW +: DW] <= en_q[hw*DW +: DW] | wdm;
          O_EC_LO, O_EC_HI: en_q[hw*DW +: DW] <= en_q[hw*DW +: DW] & ~wdm;
          O_QEN:            qen_q <= (qen_q & ~qm) | qwd;
          O_QS:             qen_q <= qen_q | qwd;
          O_QC:             qen_q <= qen_q & ~qwd;
          default:
            if (in_mask) begin
              case (mfld)
                2'd0:    dmask_q[mreg][DW-1:0]   <= bus_wdata;
                2'd1:    dmask_q[mreg][NCH-1:DW] <= bus_wdata;
                2'd2:    qmask_q[mreg]           <= bus_wdata[QN-1:0];
                default: ;
              endcase
            end
        endcase
      end
    end
  end

  assign chan_en  = en_q;
  assign qchan_en = qen_q;

  for (genvar k = 0; k < NR; k++) begin : g_irq
    assign region_irq[k] = |(pend_q & dmask_q[k]);
  end
endmodule

// File: rtl/shadow_access_filter_chk.sv
module shadow_access_filter_chk #(
  parameter int NR   = 8,
  parameter int DW   = 32,
  parameter int QN   = 4,
  parameter int VW   = 4,
  parameter int OFFW = 6,
  parameter int CW   = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_we,
  input logic [VW+OFFW-1:0]     bus_addr,
  input logic [DW-1:0]          bus_rdata,
  input logic                   done_valid,
  input logic [CW-1:0]          done_code,
  input logic [2*DW-1:0]        chan_en,
  input logic [QN-1:0]          qchan_en,
  input logic [NR-1:0][2*DW-1:0] dmask,
  input logic [NR-1:0][QN-1:0]  qmask,
  input logic [2*DW-1:0]        pend
);
  localparam int RW = $clog2(NR);
  wire [VW-1:0] view = bus_addr[VW+OFFW-1:OFFW];
  wire [RW-1:0] sv   = view[RW-1:0];
  wire shd_wr = bus_valid && bus_we && (int'(view) < NR);
  wire bad_v  = bus_valid && (int'(view) > NR);

  AST_SHADOW_EN_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    shd_wr |=> ((chan_en ^ $past(chan_en)) & ~$past(dmask[sv])) == '0); // R3
  AST_SHADOW_QEN_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
    shd_wr |=> ((qchan_en ^ $past(qchan_en)) & ~$past(qmask[sv])) == '0); // R7
  AST_SHADOW_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    shd_wr |=> ($stable(dmask) && $stable(qmask))); // R8
  AST_UNDECODED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_v && bus_we) |=> ($stable(chan_en) && $stable(qchan_en) && $stable(dmask) && $stable(qmask))); // R9
  AST_UNDECODED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_v && !bus_we) |=> bus_rdata == '0); // R9
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_we) |=> bus_rdata == '0); // R11
  AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> pend[$past(done_code)]); // R6
endmodule

bind shadow_access_filter shadow_access_filter_chk #(
  .NR(NR), .DW(DW), .QN(QN), .VW(VW), .OFFW(OFFW), .CW(CW)
) chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .done_valid(done_valid),
  .done_code(done_code), .chan_en(chan_en), .qchan_en(qchan_en),
  .dmask(dmask_q), .qmask(qmask_q), .pend(pend_q)
);

// File: tb/shadow_access_filter_test.sv
module shadow_access_filter_test;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_we = 0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        done_valid = 0;
  logic [5:0]  done_code = '0;
  logic [63:0] chan_en;
  logic [3:0]  qchan_en;
  logic [7:0]  region_irq;
  int n_chk = 0, n_bad = 0;
  localparam int G = 8;

  always #2 clk = ~clk;

  shadow_access_filter uut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int v, input int o, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = {v[3:0], o[5:0]}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input int v, input int o, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = {v[3:0], o[5:0]};
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic done(input int c);
    @(negedge clk);
    done_valid = 1; done_code = c[5:0];
    @(negedge clk);
    done_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 chan_en", chan_en, 0);
    check("R1 qchan_en", qchan_en, 0);
    check("R1 irq", region_irq, 0);
    check("R1 rdata", bus_rdata, 0);
  endtask

  task automatic t_global;
    logic [31:0] d;
    wr(G, 0, 32'hA5A5_0F0F); rd(G, 0, d);
    check("R2 global read lo", d, 32'hA5A5_0F0F);
    wr(G, 1, 32'h1234_5678);
    check("R2 global write hi", chan_en, 64'h1234_5678_A5A5_0F0F);
    wr(G, 32, 32'h0000_FFFF); rd(G, 32, d);
    check("R2 mask r0 lo readback", d, 32'h0000_FFFF);
    wr(G, 0, 0); wr(G, 1, 0);
  endtask

  task automatic t_shadow_write;
    wr(0, 0, 32'hFFFF_FFFF);
    check("R3 r0 owned bits written", chan_en, 64'h0000_FFFF);
    wr(5, 0, 32'h0);
    check("R3 r5 owns nothing", chan_en, 64'h0000_FFFF);
    wr(0, 0, 32'h0);
    check("R3 r0 clears own bits", chan_en, 0);
  endtask

  task automatic t_shadow_read;
    logic [31:0] d;
    wr(G, 0, 32'h1234_5678);
    rd(0, 0, d); check("R4 r0 filtered read", d, 32'h0000_5678);
    rd(5, 0, d); check("R4 r5 read zero", d, 0);
    wr(G, 0, 0);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(G, 37, 32'h0000_00F0);
    wr(1, 3, 32'hFF);
    check("R5 set masked", chan_en, 64'h0000_00F0_0000_0000);
    wr(1, 5, 32'h30);
    check("R5 clear masked", chan_en, 64'h0000_00C0_0000_0000);
    wr(1, 5, 32'h0);
    check("R5 zero clear no-op", chan_en, 64'h0000_00C0_0000_0000);
    wr(1, 2, 32'hFFFF_FFFF);
    check("R5 unowned set no-op", chan_en, 64'h0000_00C0_0000_0000);
    rd(G, 2, d); check("R5 set alias reads zero", d, 0);
    wr(G, 5, 32'hFFFF_FFFF);
    check("R5 global clear", chan_en, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(G, 40, 32'h8);
    done(3);
    check("R6 irq shared code 3", region_irq, 8'b0000_0101);
    done(40);
    rd(G, 7, d); check("R6 global pending hi", d, 32'h100);
    rd(1, 7, d); check("R6 r1 pending hi filtered", d, 0);
    wr(2, 8, 32'h8);
    check("R6 r2 clear", region_irq, 0);
    wr(5, 9, 32'h100);
    rd(G, 7, d); check("R6 unowned clear ignored", d, 32'h100);
    wr(G, 9, 32'h100);
    rd(G, 7, d); check("R6 global clear", d, 0);
  endtask

  task automatic t_qdma;
    logic [31:0] d;
    wr(G, 46, 32'h5);
    wr(3, 11, 32'hF); check("R7 r3 set", qchan_en, 4'h5);
    wr(4, 11, 32'hF); check("R7 r4 set ignored", qchan_en, 4'h5);
    rd(4, 10, d);     check("R7 r4 read zero", d, 0);
    wr(3, 12, 32'hF); check("R7 r3 clear", qchan_en, 4'h0);
    wr(G, 11, 32'hA);
    wr(3, 12, 32'hF); check("R7 r3 clear unowned", qchan_en, 4'hA);
    rd(3, 10, d);     check("R7 r3 read filtered", d, 0);
    wr(G, 12, 32'hF);
  endtask

  task automatic t_mask_prot;
    logic [31:0] d;
    wr(0, 32, 32'h0);
    rd(G, 32, d); check("R8 mask untouched", d, 32'h0000_FFFF);
    rd(0, 32, d); check("R8 shadow mask read zero", d, 0);
  endtask

  task automatic t_undec;
    logic [31:0] d;
    wr(9, 0, 32'hFFFF_FFFF); check("R9 view 9 write", chan_en, 0);
    wr(G, 0, 32'h77);
    rd(15, 0, d);  check("R9 view 15 read", d, 0);
    rd(G, 13, d);  check("R9 offset 13 read", d, 0);
    rd(G, 35, d);  check("R9 field 3 read", d, 0);
    wr(G, 35, 32'hFFFF_FFFF);
    rd(G, 32, d);  check("R9 field 3 write", d, 32'h0000_FFFF);
    wr(G, 0, 0);
  endtask

  task automatic t_shared;
    logic [31:0] d;
    wr(G, 56, 32'h1); wr(G, 60, 32'h1);
    wr(6, 2, 32'h1); check("R10 r6 sets bit 0", chan_en, 64'h1);
    rd(7, 0, d);     check("R10 r7 sees bit 0", d, 32'h1);
    wr(7, 4, 32'h1); check("R10 r7 clears bit 0", chan_en, 0);
  endtask

  task automatic t_rdtiming;
    logic [31:0] d;
    wr(G, 0, 32'h55);
    rd(G, 0, d); check("R11 data next cycle", d, 32'h55);
    @(negedge clk); check("R11 idle rdata zero", bus_rdata, 0);
    wr(G, 0, 0);
    check("R11 write cycle rdata zero", bus_rdata, 0);
  endtask

  initial begin
    #(4*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_global; t_shadow_write; t_shadow_read; t_setclr;
    t_irq; t_qdma; t_mask_prot; t_undec; t_shared; t_rdtiming;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule